// File: doc/BRIEF.md
# Fault Input Glitch Filter

This block conditions an asynchronous fault pin before a fault is recognised. The pin is first resynchronised into the system clock domain through a chain of flip-flops. It then passes through a counter-based glitch filter. A new level is accepted only once the synchronised input has held it for the number of clocks given by a 4-bit length input. The accepted level goes through one delay stage and then a registered rising-edge detector. The detector raises a single-cycle fault event.

A length of zero bypasses the filter. In that case the total latency from pin to event is fixed at four clock edges. With a nonzero length N the latency is 4 + N edges. Shorter disturbances never reach the edge detector. The delayed filtered level is brought out next to the event so that the accepted waveform can be observed.

Top module: `fault_glitch_filter`

## Requirements
- R1: While reset is high, and at the first clock edge after it, fault_evt and fault_level are 0. Reset clears the synchronizer, the filter counter and the accepted level.
- R2: With filt_len = 0, a pin level first sampled at clock edge 1 makes fault_evt high after edge 4.
- R3: With filt_len = N (1 to 15), a held rising level first sampled at edge 1 makes fault_evt high after edge 4 + N.
- R4: With filt_len = N > 0, a high pulse sampled on fewer than N consecutive edges produces no event, and fault_level stays 0.
- R5: With filt_len = N > 0, a high pulse sampled on exactly N consecutive edges is accepted and gives an event after edge 4 + N.
- R6: If the input returns to the accepted level before the count completes, the count is discarded. Counting starts again from zero at the next differing sample.
- R7: A falling filtered level produces no event. fault_evt is high only when fault_level was 1 one cycle earlier and 0 two cycles earlier.
- R8: fault_evt is never high for two consecutive cycles.
- R9: A change of filt_len takes effect at once and restarts any count in progress. The edge that samples the new value counts as zero.
- R10: With filt_len = 0, even a single-sample pulse is passed through. fault_level follows the pin sampled three edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_pin | input | 1 | Asynchronous fault input |
| filt_len | input | 4 | Minimum accepted pulse width in clocks; 0 bypasses the filter |
| fault_evt | output | 1 | One-cycle pulse on an accepted rising fault level |
| fault_level | output | 1 | Filtered and delayed fault level |

## Verification
The hardest condition to reach from the ports is an interrupted count. This is an input that turns back just one sample short of acceptance, or a filter length that changes while a count is running. The stimulus produces these with sample-exact pin patterns, driven away from the clock edge. One pattern drops the pin for a single sample inside an otherwise long-enough pulse. Another rewrites filt_len partway through a count. The expected event edge differs by several cycles between a count that restarts and one that does not.

// File: rtl/fflt_pkg.sv
package fflt_pkg;

    localparam int FLT_LEN_W      = 4;
    localparam int FLT_CNT_W      = 5;
    localparam int FLT_SYNC_DEPTH = 2;

    typedef enum logic {
        FM_BYPASS = 1'b0,
        FM_FILTER = 1'b1
    } filt_mode_e;

    typedef struct packed {
        logic dly;
        logic prev;
        logic evt;
    } edge_stage_t;

    function automatic filt_mode_e mode_of(input logic [FLT_LEN_W-1:0] len);
        return (len == '0) ? FM_BYPASS : FM_FILTER;
    endfunction

endpackage

// File: rtl/fflt_sync.sv
module fflt_sync #(
    parameter int DEPTH = fflt_pkg::FLT_SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [DEPTH-1:0] chain;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[DEPTH-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[DEPTH-1];
endmodule

// File: rtl/fflt_counter.sv
module fflt_counter
    import fflt_pkg::*;
#(
    parameter int LEN_W = FLT_LEN_W,
    parameter int CNT_W = FLT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [LEN_W-1:0] len,
    output logic             level
);
    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] len_seen;
    logic             held;
    logic [CNT_W-1:0] target;
    filt_mode_e       mode;

    assign mode   = mode_of(len);
    assign target = CNT_W'(len) - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            held     <= 1'b0;
            len_seen <= '0;
        end else begin
            len_seen <= len;
            if (mode == FM_BYPASS) begin
                held <= din;
                cnt  <= '0;
            end else if (len != len_seen) begin
                cnt <= '0;
            end else if (din == held) begin
                cnt <= '0;
            end else if (cnt == target) begin
                held <= din;
                cnt  <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assign level = (mode == FM_BYPASS) ? din : held;
endmodule

// File: rtl/fflt_edge.sv
module fflt_edge
    import fflt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl_in,
    output logic lvl_out,
    output logic rise_evt
);
    edge_stage_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.dly  <= lvl_in;
            st.prev <= st.dly;
            st.evt  <= st.dly & ~st.prev;
        end
    end

    assign lvl_out  = st.dly;
    assign rise_evt = st.evt;
endmodule

// File: rtl/fault_glitch_filter.sv
module fault_glitch_filter
    import fflt_pkg::*;
#(
    parameter int LEN_W      = FLT_LEN_W,
    parameter int CNT_W      = FLT_CNT_W,
    parameter int SYNC_DEPTH = FLT_SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fault_pin,
    input  logic [LEN_W-1:0] filt_len,
    output logic             fault_evt,
    output logic             fault_level
);
    logic pin_sync;
    logic lvl_filt;

    fflt_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (fault_pin),
        .q_sync  (pin_sync)
    );

    fflt_counter #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .din   (pin_sync),
        .len   (filt_len),
        .level (lvl_filt)
    );

    fflt_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .lvl_in   (lvl_filt),
        .lvl_out  (fault_level),
        .rise_evt (fault_evt)
    );
endmodule

// File: rtl/fault_glitch_filter_chk.sv
module fault_glitch_filter_chk #(
    parameter int LEN_W = fflt_pkg::FLT_LEN_W
) (
    input logic             clk,
    input logic             rst,
    input logic             fault_pin,
    input logic [LEN_W-1:0] filt_len,
    input logic             fault_evt,
    input logic             fault_level
);
    logic [1:0] warm;
    logic       ready;

    always_ff @(posedge clk) begin
        if (rst)              warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end
    assign ready = (warm == 2'd3);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!fault_evt && !fault_level));

    // R8
    evt_single_chk: assert property (@(posedge clk) disable iff (rst)
        fault_evt |=> !fault_evt);

    // R7
    evt_rise_only_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && fault_evt) |-> ($past(fault_level) && !$past(fault_level, 2)));

    // R10
    bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && $past(filt_len) == '0) |-> (fault_level == $past(fault_pin, 3)));
endmodule

bind fault_glitch_filter fault_glitch_filter_chk #(.LEN_W(LEN_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .fault_pin   (fault_pin),
    .filt_len    (filt_len),
    .fault_evt   (fault_evt),
    .fault_level (fault_level)
);

// File: tb/fault_glitch_filter_test.sv
module fault_glitch_filter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fault_pin = 1'b0;
    logic [3:0] filt_len = 4'd0;
    logic       fault_evt;
    logic       fault_level;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    fault_glitch_filter uut (
        .clk         (clk),
        .rst         (rst),
        .fault_pin   (fault_pin),
        .filt_len    (filt_len),
        .fault_evt   (fault_evt),
        .fault_level (fault_level)
    );

    // Behavioural reference: sample history, run length, delay taps
    int m_s1, m_s2, m_acc, m_run, m_lenp, m_dly, m_dlyp, m_evt;
    always @(posedge clk) begin
        int n;
        int nd;
        n = int'(filt_len);
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_acc = 0; m_run = 0;
            m_lenp = 0; m_dly = 0; m_dlyp = 0; m_evt = 0;
        end else begin
            m_evt  = (m_dly == 1 && m_dlyp == 0) ? 1 : 0;
            m_dlyp = m_dly;
            nd     = (n == 0) ? m_s2 : m_acc;
            m_dly  = nd;
            if (n == 0) begin
                m_acc = m_s2; m_run = 0;
            end else if (n != m_lenp) begin
                m_run = 0;
            end else if (m_s2 == m_acc) begin
                m_run = 0;
            end else if (m_run + 1 >= n) begin
                m_acc = m_s2; m_run = 0;
            end else begin
                m_run = m_run + 1;
            end
            m_lenp = n;
            m_s2 = m_s1;
            m_s1 = int'(fault_pin);
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            tests++;
            if (int'(fault_evt) != m_evt || int'(fault_level) != m_dly) begin
                fails++;
                $display("FAIL model(R3): evt=%0d level=%0d expected evt=%0d level=%0d",
                         fault_evt, fault_level, m_evt, m_dly);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // pat bit k-1 is the pin level sampled at edge k
    task automatic run_pat(input string tag, input int len, input logic [31:0] pat,
                           input int nbits, input int chg_at, input int new_len,
                           input int exp_edge);
        int first = 0;
        int highs = 0;
        int lvl_seen = 0;
        int after = -1;
        filt_len = 4'(len);
        fault_pin = 1'b0;
        repeat (40) @(negedge clk);
        fault_pin = pat[0];
        for (int k = 1; k <= 60; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (fault_evt) begin
                highs++;
                if (first == 0) first = k;
            end
            if (fault_level) lvl_seen = 1;
            if (exp_edge != 0 && k == exp_edge + 1) after = int'(fault_evt);
            if (k == chg_at) filt_len = 4'(new_len);
            fault_pin = (k < nbits) ? pat[k] : 1'b0;
        end
        check({tag, " event edge"}, first, exp_edge);
        // R7: a falling level never adds a second event
        check({"R7 ", tag, " event count"}, highs, (exp_edge != 0) ? 1 : 0);
        if (exp_edge == 0) check({"R4 ", tag, " level stayed 0"}, lvl_seen, 0);
        else               check({"R8 ", tag, " evt low next cycle"}, after, 0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        fault_pin = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 evt in reset", int'(fault_evt), 0);
        check("R1 level in reset", int'(fault_level), 0);
        rst = 1'b0;
        fault_pin = 1'b0;
        @(negedge clk);
        check("R1 evt after reset", int'(fault_evt), 0);
        check("R1 level after reset", int'(fault_level), 0);

        run_pat("R2 bypass held",      0,  32'h3FF,   10, 0, 0, 4);
        run_pat("R10 bypass 1 sample", 0,  32'h1,      1, 0, 0, 4);
        run_pat("R3 len3",             3,  32'h3FF,   10, 0, 0, 7);
        run_pat("R3 len15",            15, 32'hFFFFF, 20, 0, 0, 19);
        run_pat("R5 len1 1 sample",    1,  32'h1,      1, 0, 0, 5);
        run_pat("R4 len5 4 samples",   5,  32'hF,      4, 0, 0, 0);
        run_pat("R4 len15 14 samples", 15, 32'h3FFF,  14, 0, 0, 0);
        run_pat("R5 len5 5 samples",   5,  32'h1F,     5, 0, 0, 9);
        run_pat("R6 broken count",     4,  32'h77,     7, 0, 0, 0);
        run_pat("R6 recount",          4,  32'hF7,     8, 0, 0, 12);
        run_pat("R9 len change",       6,  32'hFFFFF, 20, 5, 4, 12);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule